// File: doc/BRIEF.md
# Status-Lock Write Controller

This block is the receive side of a serial-flash command port, reduced to what is needed to update the status lock bit. It listens to a four-wire serial bus in mode 0 with the most significant bit first. SI is sampled on rising SCK edges while chip select is low. All bus pins are first brought into the system clock domain through synchronizer flops. The first whole byte of a frame is taken as the opcode and the second whole byte as the data. Anything after that is dropped. The command acts when chip select rises.

The block holds two state bits: a write-enable latch and a lock bit. Opcode 06h arms the latch and opcode 04h disarms it. Opcode 01h writes the lock bit from data bit 7. That write happens only if the latch was armed, the frame ended on a byte boundary, and the write-protect pin permits it. Data bits 5..2, read together with the lock value held before the command, may raise a one-cycle global protect or global unprotect request for a neighbouring protection array.

Top module: `sreg_wr_ctrl`

## Requirements
- R1: After reset `wel` and `lock_bit` are 0, and neither request output is high.
- R2: A frame whose opcode byte is 06h sets `wel`, and one whose opcode byte is 04h clears `wel`. Either acts only when chip select rises after a whole number of bytes. A frame whose bit count is not a multiple of 8, or whose opcode is unknown, leaves `wel` unchanged.
- R3: An opcode 01h frame received while `wel` is 0 changes neither `lock_bit` nor `wel`, and raises no request.
- R4: An opcode 01h frame of 16 or more bits, ending on a byte boundary while `wel` is 1, loads data bit 7 into `lock_bit` and clears `wel`. Data bits 6, 1 and 0 have no effect.
- R5: Bytes that follow the first data byte have no effect on the result.
- R6: An opcode 01h frame that ends before 16 bits, or not on a multiple of 8 bits, leaves `lock_bit` unchanged, raises no request, and clears `wel`.
- R7: While `wp_n` is low, an opcode 01h write with data bit 7 = 0 is ignored: `lock_bit` is unchanged, no request is raised, and `wel` is cleared. With data bit 7 = 1 the write proceeds.
- R8: An accepted write with data bits 5..2 = 1111 and prior `lock_bit` = 0 pulses `glob_protect` high for exactly one clock.
- R9: An accepted write with data bits 5..2 = 0000 and prior `lock_bit` = 0 pulses `glob_unprotect` high for exactly one clock.
- R10: No request is raised when the prior `lock_bit` is 1, or for any other code in bits 5..2. The two request outputs are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock, mode 0 |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_si | input | 1 | Serial data in, MSB first |
| wp_n | input | 1 | Write-protect pin, active low |
| wel | output | 1 | Write-enable latch |
| lock_bit | output | 1 | Status lock bit |
| glob_protect | output | 1 | One-cycle global protect request |
| glob_unprotect | output | 1 | One-cycle global unprotect request |

## Verification
A wrong bit index or byte count in the frame shifter shows up at the ports a few system clocks after chip select rises. The symptoms are a latch that stays armed after an aborted frame, or a lock bit loaded from the wrong data bit. A wrong prior-lock or write-protect decision shows as a missing, extra or doubled request pulse in the same cycle that `wel` drops. The sweep walks every combination of prior lock, pin state, latch state, bit 7 and protect code. Every decision path is therefore observed through the ports within one frame.

// File: rtl/sreg_pkg.sv
package sreg_pkg;
    localparam int unsigned BYTE_W    = 8;
    localparam int unsigned BIT_IDX_W = $clog2(BYTE_W);
    localparam int unsigned CODE_W    = 4;

    localparam logic [BYTE_W-1:0] OP_WRITE_LOCK = 8'h01;
    localparam logic [BYTE_W-1:0] OP_ARM        = 8'h06;
    localparam logic [BYTE_W-1:0] OP_DISARM     = 8'h04;

    localparam logic [CODE_W-1:0] CODE_PROTECT   = 4'b1111;
    localparam logic [CODE_W-1:0] CODE_UNPROTECT = 4'b0000;

    // Count of whole bytes seen in a frame, saturating after the data byte
    typedef enum logic [1:0] {
        NB_NONE   = 2'd0,
        NB_OPCODE = 2'd1,
        NB_DATA   = 2'd2
    } nbytes_e;

    typedef struct packed {
        logic                  sck_prev;
        logic                  cs_prev;
        logic [BIT_IDX_W-1:0]  bit_idx;
        nbytes_e               nbytes;
        logic [BYTE_W-1:0]     shreg;
        logic [BYTE_W-1:0]     opcode;
        logic [BYTE_W-1:0]     data;
        logic                  done;
    } frame_st_t;

    typedef struct packed {
        logic wel;
        logic lock;
        logic gp;
        logic gu;
    } exec_st_t;
endpackage

// File: rtl/sreg_sync.sv
module sreg_sync #(
    parameter int unsigned W       = 4,
    parameter int unsigned STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [STAGES-1:0][W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = din;
        for (int s = 1; s < int'(STAGES); s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/sreg_frame.sv
module sreg_frame
    import sreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_s,
    input  logic              cs_n_s,
    input  logic              si_s,
    output logic              done,
    output logic              aligned,
    output nbytes_e           nbytes,
    output logic [BYTE_W-1:0] opcode,
    output logic [BYTE_W-1:0] data
);
    frame_st_t st_d, st_q;
    logic [BYTE_W-1:0] shift_w;

    assign shift_w = {st_q.shreg[BYTE_W-2:0], si_s};

    always_comb begin
        st_d          = st_q;
        st_d.done     = 1'b0;
        st_d.sck_prev = sck_s;
        st_d.cs_prev  = cs_n_s;
        if (st_q.cs_prev && !cs_n_s) begin
            // frame start: counter restarts
            st_d.bit_idx = '0;
            st_d.nbytes  = NB_NONE;
        end else if (!cs_n_s && sck_s && !st_q.sck_prev) begin
            st_d.shreg   = shift_w;
            st_d.bit_idx = st_q.bit_idx + 1'b1;
            if (st_q.bit_idx == BIT_IDX_W'(BYTE_W-1)) begin
                unique case (st_q.nbytes)
                    NB_NONE: begin
                        st_d.opcode = shift_w;
                        st_d.nbytes = NB_OPCODE;
                    end
                    NB_OPCODE: begin
                        st_d.data   = shift_w;
                        st_d.nbytes = NB_DATA;
                    end
                    default: st_d.nbytes = NB_DATA;
                endcase
            end
        end
        if (!st_q.cs_prev && cs_n_s) begin
            st_d.done = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.cs_prev  <= 1'b1;
            st_q.nbytes   <= NB_NONE;
        end else begin
            st_q <= st_d;
        end
    end

    assign done    = st_q.done;
    assign aligned = (st_q.bit_idx == '0);
    assign nbytes  = st_q.nbytes;
    assign opcode  = st_q.opcode;
    assign data    = st_q.data;
endmodule

// File: rtl/sreg_exec.sv
module sreg_exec
    import sreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done,
    input  logic              aligned,
    input  nbytes_e           nbytes,
    input  logic [BYTE_W-1:0] opcode,
    input  logic [BYTE_W-1:0] data,
    input  logic              wp_n_s,
    output logic              wel,
    output logic              lock,
    output logic              gp,
    output logic              gu
);
    exec_st_t st_d, st_q;
    logic              new_lock;
    logic [CODE_W-1:0] code;
    logic              dc_unused;
    logic              complete;

    assign new_lock  = data[BYTE_W-1];
    assign code      = data[BYTE_W-3 -: CODE_W];
    assign dc_unused = ^{data[BYTE_W-2], data[1:0]};
    assign complete  = aligned && (nbytes == NB_DATA);

    always_comb begin
        st_d    = st_q;
        st_d.gp = 1'b0;
        st_d.gu = 1'b0;
        if (done && nbytes != NB_NONE) begin
            if (opcode == OP_WRITE_LOCK) begin
                if (!complete) begin
                    st_d.wel = 1'b0;           // malformed frame aborts
                end else if (st_q.wel) begin
                    st_d.wel = 1'b0;
                    if (wp_n_s || new_lock) begin
                        st_d.lock = new_lock;
                        if (!st_q.lock) begin
                            st_d.gp = (code == CODE_PROTECT);
                            st_d.gu = (code == CODE_UNPROTECT);
                        end
                    end
                end
            end else if (aligned) begin
                if (opcode == OP_ARM)         st_d.wel = 1'b1;
                else if (opcode == OP_DISARM) st_d.wel = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wel  = st_q.wel;
    assign lock = st_q.lock;
    assign gp   = st_q.gp;
    assign gu   = st_q.gu;
endmodule

// File: rtl/sreg_wr_ctrl.sv
module sreg_wr_ctrl
    import sreg_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic spi_sck,
    input  logic spi_cs_n,
    input  logic spi_si,
    input  logic wp_n,
    output logic wel,
    output logic lock_bit,
    output logic glob_protect,
    output logic glob_unprotect
);
    localparam int unsigned NSYNC = 4;
    // order: {wp_n, si, cs_n, sck}; idle values of the pins
    localparam logic [NSYNC-1:0] SYNC_IDLE = 4'b1010;

    logic [NSYNC-1:0]  pins_s;
    logic              sck_s, cs_n_s, si_s, wp_s;
    logic              f_done, f_aligned;
    nbytes_e           f_nbytes;
    logic [BYTE_W-1:0] f_opcode, f_data;

    sreg_sync #(
        .W       (NSYNC),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (SYNC_IDLE)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({wp_n, spi_si, spi_cs_n, spi_sck}),
        .dout (pins_s)
    );

    assign {wp_s, si_s, cs_n_s, sck_s} = pins_s;

    sreg_frame u_frame (
        .clk    (clk),
        .rst_n  (rst_n),
        .sck_s  (sck_s),
        .cs_n_s (cs_n_s),
        .si_s   (si_s),
        .done   (f_done),
        .aligned(f_aligned),
        .nbytes (f_nbytes),
        .opcode (f_opcode),
        .data   (f_data)
    );

    sreg_exec u_exec (
        .clk    (clk),
        .rst_n  (rst_n),
        .done   (f_done),
        .aligned(f_aligned),
        .nbytes (f_nbytes),
        .opcode (f_opcode),
        .data   (f_data),
        .wp_n_s (wp_s),
        .wel    (wel),
        .lock   (lock_bit),
        .gp     (glob_protect),
        .gu     (glob_unprotect)
    );
endmodule

// File: rtl/sreg_wr_ctrl_chk.sv
module sreg_wr_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic wel,
    input logic lock,
    input logic gp,
    input logic gu,
    input logic wp_s
);
    p_req_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(gp && gu));

    p_protect_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        gp |=> !gp);

    p_unprotect_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        gu |=> !gu);

    p_req_prior_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (gp || gu) |-> (!$past(lock) && $past(wel) && !wel));

    p_lock_needs_wel_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(lock) |-> $past(wel));

    p_lock_write_clears_wel_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(lock) |-> !wel);

    p_clear_needs_pin_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lock) |-> $past(wp_s));
endmodule

bind sreg_wr_ctrl sreg_wr_ctrl_chk u_chk (
    .clk  (clk),
    .rst_n(rst_n),
    .wel  (wel),
    .lock (lock_bit),
    .gp   (glob_protect),
    .gu   (glob_unprotect),
    .wp_s (wp_s)
);

// File: tb/sreg_wr_ctrl_bench.sv
module sreg_wr_ctrl_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0, cs_n = 1'b1, si = 1'b0, wp_n = 1'b1;
    logic wel, lock_bit, gp, gu;
    int   n_chk = 0, n_bad = 0;
    int   gp_cnt = 0, gu_cnt = 0;
    int   gp0, gu0;
    bit   finished = 1'b0;

    always #2 clk = ~clk;

    sreg_wr_ctrl u_sreg_wr_ctrl (
        .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n), .spi_si(si),
        .wp_n(wp_n), .wel(wel), .lock_bit(lock_bit),
        .glob_protect(gp), .glob_unprotect(gu)
    );

    always @(posedge clk) begin
        if (gp) gp_cnt <= gp_cnt + 1;
        if (gu) gu_cnt <= gu_cnt + 1;
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic frame(input logic [23:0] pay, input int nbits);
        @(negedge clk);
        cs_n = 1'b0;
        repeat (3) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            si = pay[23-i];
            repeat (2) @(negedge clk);
            sck = 1'b1;
            repeat (2) @(negedge clk);
            sck = 1'b0;
        end
        repeat (2) @(negedge clk);
        cs_n = 1'b1;
        repeat (10) @(negedge clk);
    endtask

    task automatic arm();
        frame({8'h06, 16'h0}, 8);
    endtask

    task automatic wr(input logic [7:0] d);
        frame({8'h01, d, 8'h00}, 16);
    endtask

    task automatic snap();
        gp0 = gp_cnt;
        gu0 = gu_cnt;
    endtask

    // set lock to v with write-protect released, leaving wel = 0
    task automatic set_lock(input logic v);
        wp_n = 1'b1;
        arm();
        wr({v, 7'b0});
    endtask

    initial begin
        repeat (5) @(negedge clk);
        // R1 reset state
        chk("R1 wel", wel, 0);
        chk("R1 lock", lock_bit, 0);
        chk("R1 req", gp | gu, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk("R1 wel after release", wel, 0);

        // R2 latch control
        frame({8'h9A, 16'h0}, 8);
        chk("R2 unknown opcode", wel, 0);
        arm();
        chk("R2 arm", wel, 1);
        frame({8'h04, 16'h0}, 11);
        chk("R2 misaligned disarm ignored", wel, 1);
        frame({8'h04, 16'hFFFF}, 16);
        chk("R2 disarm", wel, 0);
        frame({8'h06, 16'h0}, 13);
        chk("R2 misaligned arm ignored", wel, 0);
        arm();
        frame({8'h5A, 16'h0}, 8);
        chk("R2 unknown keeps wel", wel, 1);

        // R6 malformed write frames
        snap();
        frame({8'h01, 8'h80, 8'h0}, 13);
        chk("R6 short lock", lock_bit, 0);
        chk("R6 short wel", wel, 0);
        arm();
        frame({8'h01, 8'h00, 8'h0}, 8);
        chk("R6 opcode only wel", wel, 0);
        arm();
        frame({8'h01, 8'hBC, 8'hE0}, 19);
        chk("R6 misaligned lock", lock_bit, 0);
        chk("R6 misaligned wel", wel, 0);
        chk("R6 no request", (gp_cnt - gp0) + (gu_cnt - gu0), 0);

        // R5 trailing bytes ignored
        arm();
        snap();
        frame({8'h01, 8'hBC, 8'h00}, 24);
        chk("R5 lock from first data byte", lock_bit, 1);
        chk("R5 one protect pulse", gp_cnt - gp0, 1);
        chk("R5 no unprotect", gu_cnt - gu0, 0);
        set_lock(1'b0);
        arm();
        snap();
        frame({8'h01, 8'h43, 8'hFF}, 24);
        chk("R5 trailing bits ignored lock", lock_bit, 0);
        chk("R5 unprotect once", gu_cnt - gu0, 1);

        // sweep: prior lock, pin, latch, bit7, code
        for (int pl = 0; pl < 2; pl++)
            for (int wpa = 0; wpa < 2; wpa++)
                for (int we = 0; we < 2; we++)
                    for (int v = 0; v < 32; v++) begin
                        logic [7:0] d;
                        logic [3:0] code;
                        logic       b7;
                        int         e_lock, e_gp, e_gu;
                        string      tag;
                        b7   = v[4];
                        code = v[3:0];
                        d    = {b7, v[2], code, v[1], ~v[0]};
                        set_lock(pl[0]);
                        if (we != 0) arm();
                        chk("R2 sweep setup wel", wel, we);
                        wp_n = (wpa == 0);
                        repeat (4) @(negedge clk);
                        snap();
                        wr(d);
                        if (we == 0) begin
                            tag = "R3"; e_lock = pl; e_gp = 0; e_gu = 0;
                        end else if (wpa != 0 && !b7) begin
                            tag = "R7"; e_lock = pl; e_gp = 0; e_gu = 0;
                        end else begin
                            tag    = "R4";
                            e_lock = b7;
                            e_gp   = (pl == 0 && code == 4'hF) ? 1 : 0;
                            e_gu   = (pl == 0 && code == 4'h0) ? 1 : 0;
                        end
                        chk({tag, " lock"}, lock_bit, e_lock);
                        chk({tag, " wel"}, wel, 0);
                        chk(e_gp != 0 ? "R8 protect" : "R10 no protect",
                            gp_cnt - gp0, e_gp);
                        chk(e_gu != 0 ? "R9 unprotect" : "R10 no unprotect",
                            gu_cnt - gu0, e_gu);
                    end
        finished = 1'b1;
    end

    initial begin
        fork
            wait (finished);
            begin
                repeat (190000) @(posedge clk);
                n_chk++;
                n_bad++;
                $display("FAIL watchdog actual=running expected=done");
            end
        join_any
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule